// File: doc/BRIEF.md
# Two-Clock FIFO with First-Word Output Register

This block carries 36-bit words from a producer clock domain to an unrelated consumer clock domain through a 256-word memory. The write side accepts a word on every write-clock edge with its enable high while the memory has room. It reports a full condition and a programmable almost-full level.

The read side works in first-word-fall-through style. The oldest unread word is moved ahead of time into an output register, and a ready flag marks that the register holds valid data. The consumer looks at the data first and then raises its read enable to take the word. A programmable almost-empty level is reported in the read domain.

Pointers cross between the domains as Gray code through two-stage synchronizers. One active-low reset clears both domains. The rising edge of that reset latches a 2-bit code that picks the almost-full and almost-empty distance.

Top module: `dual_clk_fifo`

## Requirements
- R1: After a word is written into an empty FIFO, `rd_ready` is still low after the second rising `rd_clk` edge that follows the write edge, and it is high after the third.
- R2: A `rd_en` presented while `rd_ready` is low has no effect. `rd_data` keeps its value, and no word is consumed, so the next word delivered is still the oldest unread one.
- R3: While `rd_ready` is high, `rd_data` already holds the oldest unread word. A rising `rd_clk` edge with `rd_en` and `rd_ready` both high consumes that word. Words come out in the order they were accepted.
- R4: At every edge of either clock where `rst_n` is low, that domain returns to its empty state: `rd_ready` low, `wr_full` low and `rd_data` zero. Reset is complete once `rst_n` has been held low through four edges of each clock. After reset, `rd_aempty` is high and `wr_afull` is low.
- R5: The rising edge of `rst_n` captures `ofs_sel`, and later changes on `ofs_sel` have no effect until the next reset. The code sets the offset in words as follows: 2'b00 selects 16, 2'b01 selects 12, 2'b10 selects 8 and 2'b11 selects 4.
- R6: `rd_aempty` is high exactly when the words held on the read side are at or below the offset. This count covers the words in memory as seen through the synchronized write pointer, plus one if `rd_ready` is high.
- R7: `wr_afull` is high exactly when the free memory locations, as seen through the synchronized read pointer, are at or below the offset.
- R8: `wr_full` is high when the memory holds 256 words. A write presented while `wr_full` is high is dropped and never appears at the output. Together with the output register, the block holds at most 257 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock, unrelated to wr_clk |
| rst_n | input | 1 | Active-low reset for both domains; its rising edge latches ofs_sel |
| ofs_sel | input | 2 | Offset code for almost-full and almost-empty |
| wr_en | input | 1 | Write request, taken on rising wr_clk when not full |
| wr_data | input | 36 | Word to write |
| wr_full | output | 1 | Memory holds 256 words |
| wr_afull | output | 1 | Free locations at or below the offset |
| rd_en | input | 1 | Consume the word in the output register |
| rd_data | output | 36 | Output register contents |
| rd_ready | output | 1 | Output register holds a valid word |
| rd_aempty | output | 1 | Read-side word count at or below the offset |

## Verification
On one `rd_clk` edge, a consumed word can leave the output register while the next word is loaded into it from memory. If reload and consumption were ordered wrongly, a word would be skipped or repeated. A read pattern that holds `rd_en` high two edges out of three, while writes arrive at a similar rate, makes this overlap happen many times. The scoreboard judges it by comparing every consumed word against the queue of accepted words. A second overlap is a write that arrives at the same time the full flag is set. This is provoked by a burst of 260 writes with no reads. It is judged by counting exactly 257 accepted words and by draining all of them without any dropped word appearing.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DATA_W = 36;
    localparam int ADDR_W = 8;

    // Offset select code, latched on the rising edge of reset
    typedef enum logic [1:0] {
        OFS_16 = 2'b00,
        OFS_12 = 2'b01,
        OFS_8  = 2'b10,
        OFS_4  = 2'b11
    } ofs_code_e;

    function automatic int ofs_words(input ofs_code_e code);
        return 16 - 4 * int'(code);
    endfunction

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
    parameter int AW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [AW:0] rgray_s,
    input  logic [AW:0] ofs,
    output logic        we,
    output logic        full,
    output logic        afull,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray
);
    localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [AW:0] wptr_nxt, rbin, used, free_cnt;

    always_comb begin
        full     = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        we       = wr_en & ~full;
        wptr_nxt = wptr + (AW+1)'(1);
        rbin     = g2b(rgray_s);
        used     = wptr - rbin;
        free_cnt = CAP - used;
        afull    = (free_cnt <= ofs);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (we) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [AW:0]   ofs,
    input  logic [DW-1:0] mem_q,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          ready,
    output logic          aempty
);
    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic          mem_empty, load;
    logic [AW:0]   rptr_nxt, held;

    always_comb begin
        mem_empty = (rgray == wgray_s);
        // refill the output register when it is empty or being consumed
        load      = ~mem_empty & (~ready | rd_en);
        rptr_nxt  = rptr + (AW+1)'(1);
        held      = g2b(wgray_s) - rptr + (AW+1)'(ready);
        aempty    = (held <= ofs);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
            dout  <= '0;
            ready <= 1'b0;
        end else if (load) begin
            dout  <= mem_q;
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
            ready <= 1'b1;
        end else if (rd_en) begin
            ready <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W_P = DATA_W,
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                wr_clk,
    input  logic                rd_clk,
    input  logic                rst_n,
    input  logic [1:0]          ofs_sel,
    input  logic                wr_en,
    input  logic [DATA_W_P-1:0] wr_data,
    output logic                wr_full,
    output logic                wr_afull,
    input  logic                rd_en,
    output logic [DATA_W_P-1:0] rd_data,
    output logic                rd_ready,
    output logic                rd_aempty
);
    localparam int PW = ADDR_W_P + 1;

    ofs_code_e             ofs_q;
    logic [PW-1:0]         ofs_val;
    logic [PW-1:0]         wr_ptr, wr_gray, rd_ptr, rd_gray, wr_gray_s, rd_gray_s;
    logic                  we;
    logic [DATA_W_P-1:0]   mem_q;

    // offset code captured when reset is released
    always_ff @(posedge rst_n) begin
        ofs_q <= ofs_code_e'(ofs_sel);
    end

    assign ofs_val = PW'(ofs_words(ofs_q));

    dcf_wr_ctrl #(.AW(ADDR_W_P)) u_wr (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rgray_s (rd_gray_s),
        .ofs     (ofs_val),
        .we      (we),
        .full    (wr_full),
        .afull   (wr_afull),
        .wptr    (wr_ptr),
        .wgray   (wr_gray)
    );

    dcf_sync2 #(.W(PW)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    dcf_sync2 #(.W(PW)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    dcf_ram #(.DW(DATA_W_P), .AW(ADDR_W_P)) u_ram (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (wr_ptr[ADDR_W_P-1:0]),
        .wdata (wr_data),
        .raddr (rd_ptr[ADDR_W_P-1:0]),
        .rdata (mem_q)
    );

    dcf_rd_ctrl #(.AW(ADDR_W_P), .DW(DATA_W_P)) u_rd (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wgray_s (wr_gray_s),
        .ofs     (ofs_val),
        .mem_q   (mem_q),
        .rptr    (rd_ptr),
        .rgray   (rd_gray),
        .dout    (rd_data),
        .ready   (rd_ready),
        .aempty  (rd_aempty)
    );
endmodule

// File: rtl/dual_clk_fifo_chk.sv
module dual_clk_fifo_chk #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_full,
    input logic          wr_afull,
    input logic          rd_en,
    input logic          rd_ready,
    input logic [DW-1:0] rd_data,
    input logic          rd_aempty,
    input logic [AW:0]   wr_ptr,
    input logic [AW:0]   rd_ptr
);
    assert_ready_low_in_reset_R4: assert property (@(posedge rd_clk)
        !rst_n |=> !rd_ready);

    assert_data_change_cause_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !$stable(rd_data) |-> ($past(rd_en && rd_ready) || $rose(rd_ready)));

    assert_no_consume_while_empty_R2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |-> (rd_ready && $past(rd_en || !rd_ready)));

    assert_no_overflow_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_full && wr_en) |=> (wr_ptr == $past(wr_ptr)));

    assert_full_implies_afull_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_full |-> wr_afull);

    assert_not_ready_implies_aempty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_ready |-> rd_aempty);
endmodule

bind dual_clk_fifo dual_clk_fifo_chk #(.AW(ADDR_W_P), .DW(DATA_W_P)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_full   (wr_full),
    .wr_afull  (wr_afull),
    .rd_en     (rd_en),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_aempty (rd_aempty),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/dual_clk_fifo_tb_top.sv
module dual_clk_fifo_tb_top;
    localparam int DW = 36;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ofs_sel = 2'b00;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          wr_full, wr_afull, rd_ready, rd_aempty;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_acc = 0;
    int rd_cnt = 0;
    int rd_mode = 0;
    int rd_tick = 0;
    logic [DW-1:0] sb_q[$];

    dual_clk_fifo dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full), .wr_afull(wr_afull),
        .rd_en(rd_en), .rd_data(rd_data), .rd_ready(rd_ready), .rd_aempty(rd_aempty)
    );

    // 50 MHz write clock; read clock at an unrelated 14 ns period
    always #10 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #7 rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: drives rd_en and pops the scoreboard on each consumed word
    always @(negedge rd_clk) begin : mon
        logic nxt;
        logic [DW-1:0] exp_w;
        rd_tick++;
        case (rd_mode)
            1:       nxt = 1'b1;
            2:       nxt = (rd_tick % 3) != 0;
            default: nxt = 1'b0;
        endcase
        rd_en = nxt;
        if (nxt && rd_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3", "word read with nothing expected", 64'(rd_data), 64'd0);
            end else begin
                exp_w = sb_q.pop_front();
                check(rd_data == exp_w, "R3", "read order", 64'(rd_data), 64'(exp_w));
                rd_cnt++;
            end
        end
    end

    task automatic put(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (!wr_full) begin
            sb_q.push_back(d);
            n_acc++;
        end
    endtask

    task automatic idle_w();
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_w(input int n);
        repeat (n) @(negedge wr_clk);
    endtask

    task automatic do_reset(input logic [1:0] code);
        rd_mode = 0;
        @(negedge wr_clk);
        wr_en   = 1'b0;
        rst_n   = 1'b0;
        ofs_sel = code;
        repeat (5) @(negedge wr_clk);
        // R4: state while reset is held
        check(rd_ready == 1'b0, "R4", "ready during reset", 64'(rd_ready), 64'd0);
        check(wr_full == 1'b0, "R4", "full during reset", 64'(wr_full), 64'd0);
        sb_q.delete();
        rd_cnt = 0;
        n_acc  = 0;
        rst_n  = 1'b1;
        wait_w(3);
    endtask

    initial begin : watchdog
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] first_w;

        // ---- reset state (R4)
        do_reset(2'b00);
        check(rd_aempty == 1'b1, "R4", "aempty after reset", 64'(rd_aempty), 64'd1);
        check(wr_afull == 1'b0, "R4", "afull after reset", 64'(wr_afull), 64'd0);
        check(rd_data == '0, "R4", "data after reset", 64'(rd_data), 64'd0);

        // ---- reads while empty are ignored (R2)
        rd_mode = 1;
        wait_w(10);
        rd_mode = 0;
        wait_w(2);
        check(rd_ready == 1'b0, "R2", "ready after empty reads", 64'(rd_ready), 64'd0);
        check(rd_data == '0, "R2", "data after empty reads", 64'(rd_data), 64'd0);

        // ---- three-edge ready latency (R1)
        first_w = 36'h9_1234_5678;
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = first_w;
        sb_q.push_back(first_w);
        @(posedge wr_clk);
        wr_en <= 1'b0;
        @(posedge rd_clk);
        @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b0, "R1", "ready after second edge", 64'(rd_ready), 64'd0);
        @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b1, "R1", "ready after third edge", 64'(rd_ready), 64'd1);
        check(rd_data == first_w, "R3", "first word before read", 64'(rd_data), 64'(first_w));
        for (int i = 0; i < 4; i++) put(36'h2_0000_0000 + 36'(i));
        idle_w();
        rd_mode = 1;
        wait_w(20);
        check(sb_q.size() == 0, "R3", "queue drained", 64'(sb_q.size()), 64'd0);
        check(rd_cnt == 5, "R2", "words delivered after empty reads", 64'(rd_cnt), 64'd5);
        check(rd_ready == 1'b0, "R3", "ready after drain", 64'(rd_ready), 64'd0);

        // ---- full blocks writes (R8)
        do_reset(2'b00);
        for (int i = 0; i < 260; i++) put(36'h3_0000_0000 + 36'(i));
        idle_w();
        wait_w(8);
        check(n_acc == 257, "R8", "accepted words", 64'(n_acc), 64'd257);
        check(wr_full == 1'b1, "R8", "full flag", 64'(wr_full), 64'd1);
        check(wr_afull == 1'b1, "R7", "afull when full", 64'(wr_afull), 64'd1);
        put(36'hD_EAD0_0000);
        idle_w();
        rd_mode = 1;
        wait_w(400);
        check(sb_q.size() == 0, "R8", "queue drained after full", 64'(sb_q.size()), 64'd0);
        check(rd_cnt == 257, "R8", "words read after full", 64'(rd_cnt), 64'd257);
        check(rd_ready == 1'b0, "R8", "no dropped word appears", 64'(rd_ready), 64'd0);

        // ---- mixed traffic, reload and consume on one edge (R3)
        do_reset(2'b01);
        rd_mode = 2;
        for (int i = 0; i < 120; i++) begin
            put(36'h5_0000_0000 + 36'(i * 3));
            if (i % 7 == 6) begin
                idle_w();
                wait_w(2);
            end
        end
        idle_w();
        wait_w(100);
        check(sb_q.size() == 0, "R3", "mixed queue drained", 64'(sb_q.size()), 64'd0);
        check(rd_cnt == 120, "R3", "mixed words read", 64'(rd_cnt), 64'd120);

        // ---- offset codes (R5, R6, R7)
        for (int c = 0; c < 4; c++) begin
            int off;
            off = 16 - 4 * c;
            do_reset(2'(c));
            for (int i = 0; i < off; i++) put(36'h7_0000_0000 + 36'(i));
            idle_w();
            wait_w(10);
            check(rd_aempty == 1'b1, "R6", "aempty at offset", 64'(rd_aempty), 64'd1);
            put(36'h7_1000_0000);
            idle_w();
            wait_w(10);
            check(rd_aempty == 1'b0, "R6", "aempty above offset", 64'(rd_aempty), 64'd0);
            for (int i = off + 1; i < 256 - off; i++) put(36'h7_2000_0000 + 36'(i));
            idle_w();
            wait_w(10);
            check(wr_afull == 1'b0, "R7", "afull one above offset", 64'(wr_afull), 64'd0);
            put(36'h7_3000_0000);
            idle_w();
            wait_w(10);
            check(wr_afull == 1'b1, "R7", "afull at offset", 64'(wr_afull), 64'd1);
            ofs_sel = ~2'(c);
            wait_w(4);
            check(wr_afull == 1'b1, "R5", "afull after pin change", 64'(wr_afull), 64'd1);
            check(rd_aempty == 1'b0, "R5", "aempty after pin change", 64'(rd_aempty), 64'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule